// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This peripheral guards a system against software that stops responding. A down-counter runs while enabled. When it reaches zero for the first time it raises an interrupt and starts over from the programmed reload value. If it reaches zero again before software has acknowledged that interrupt, the block issues a one-cycle system reset request, provided reset escalation is enabled.

Software reaches the block over a plain register bus: a byte address, a write strobe, write data, and combinational read data. A key register guards every other register. Writes only take effect after the key register has been given the unlock constant 32'h1ACCE551. Writing any other value, usually the bitwise inverse of that constant, locks the registers again. Reads are never blocked. Acknowledging the interrupt also restarts the countdown. Software therefore services the watchdog with one sequence: unlock, write the acknowledge register, lock.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the key register reads 1 (locked), the reload register reads 32'hFFFFFFFF, the control register reads 0, the status register reads 0, and both `irq_o` and `sys_rst_o` are low.
- R2: While locked, writes to offsets 0x000 (reload), 0x008 (control) and 0x00C (acknowledge) have no effect.
- R3: Writing 32'h1ACCE551 to offset 0xC00 unlocks the registers, and the key register then reads 0. Writing any other value to that offset locks them, and the key register then reads 1.
- R4: A permitted write to the reload register (offset 0x000) also loads the counter, so the count register (offset 0x004) shows the new value in the next cycle.
- R5: In the control register (offset 0x008), bit 0 enables reset escalation and bit 1 enables both counting and the interrupt. Bits 31:2 read as zero.
- R6: While control bit 1 is set, the counter decreases by one each clock. While it is clear, the counter holds its value. Setting the bit again resumes counting from the held value.
- R7: When the counter is at zero and counting is enabled, the next clock edge sets the pending interrupt and reloads the counter from the reload register.
- R8: If the counter expires while the interrupt is already pending and control bit 0 is set, `sys_rst_o` goes high for exactly one cycle, and the interrupt stays pending.
- R9: If control bit 0 is clear, a second expiry never raises `sys_rst_o`, and the interrupt simply stays pending.
- R10: A permitted write to offset 0x00C with data bit 0 = 1 clears the pending interrupt and reloads the counter from the reload register. A write with bit 0 = 0 changes nothing.
- R11: `irq_o` and the status register (offset 0x014, bit 0) show the pending interrupt ANDed with control bit 1.
- R12: All registers can be read while locked, and the count register always shows the live counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_we | input | 1 | Write strobe; one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Watchdog interrupt, masked by control bit 1 |
| sys_rst_o | output | 1 | One-cycle system reset request |

## Verification
The case that is hardest to reach is a second expiry while the interrupt is still pending. With the default reload of all ones it would take billions of cycles. The stimulus unlocks the block and programs a reload of only a few counts, then leaves the interrupt unacknowledged. The bench then times the reset pulse to the exact edge, and it does so once with escalation enabled and once with it disabled. Locked-write rejection is checked by trying reload, acknowledge and control writes while locked and reading back the registers they would have changed.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
    // Register offsets (byte addresses)
    localparam logic [11:0] OFF_RELOAD = 12'h000;
    localparam logic [11:0] OFF_COUNT  = 12'h004;
    localparam logic [11:0] OFF_CTRL   = 12'h008;
    localparam logic [11:0] OFF_ACK    = 12'h00C;
    localparam logic [11:0] OFF_STATUS = 12'h014;
    localparam logic [11:0] OFF_KEY    = 12'hC00;

    localparam logic [31:0] UNLOCK_KEY = 32'h1ACCE551;

    // Control bit positions
    localparam int CTRL_RSTEN_BIT = 0;
    localparam int CTRL_RUN_BIT   = 1;
endpackage

// File: rtl/kwd_regfile.sv
module kwd_regfile
    import kwd_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              irq_vis,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [CNT_W-1:0]  reload_val,
    output logic [CNT_W-1:0]  load_data,
    output logic              run_en,
    output logic              rst_en,
    output logic              load_wr,
    output logic              ack_wr
);
    typedef struct packed {
        logic             locked;
        logic [CNT_W-1:0] reload;
        logic             run;
        logic             rsten;
    } regs_t;

    regs_t st_d, st_q;

    logic sel_reload, sel_count, sel_ctrl, sel_ack, sel_status, sel_key;
    logic open_wr;

    always_comb begin
        sel_reload = (bus_addr == ADDR_W'(OFF_RELOAD));
        sel_count  = (bus_addr == ADDR_W'(OFF_COUNT));
        sel_ctrl   = (bus_addr == ADDR_W'(OFF_CTRL));
        sel_ack    = (bus_addr == ADDR_W'(OFF_ACK));
        sel_status = (bus_addr == ADDR_W'(OFF_STATUS));
        sel_key    = (bus_addr == ADDR_W'(OFF_KEY));
        open_wr    = bus_we && !st_q.locked;

        st_d = st_q;
        if (bus_we && sel_key) begin
            st_d.locked = (bus_wdata != DATA_W'(UNLOCK_KEY));
        end
        if (open_wr && sel_reload) begin
            st_d.reload = bus_wdata[CNT_W-1:0];
        end
        if (open_wr && sel_ctrl) begin
            st_d.run   = bus_wdata[CTRL_RUN_BIT];
            st_d.rsten = bus_wdata[CTRL_RSTEN_BIT];
        end

        load_wr   = open_wr && sel_reload;
        ack_wr    = open_wr && sel_ack && bus_wdata[0];
        load_data = bus_wdata[CNT_W-1:0];

        bus_rdata = '0;
        if (sel_reload) begin
            bus_rdata = DATA_W'(st_q.reload);
        end else if (sel_count) begin
            bus_rdata = DATA_W'(cnt_val);
        end else if (sel_ctrl) begin
            bus_rdata[CTRL_RUN_BIT]   = st_q.run;
            bus_rdata[CTRL_RSTEN_BIT] = st_q.rsten;
        end else if (sel_status) begin
            bus_rdata[0] = irq_vis;
        end else if (sel_key) begin
            bus_rdata[0] = st_q.locked;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.locked <= 1'b1;
            st_q.reload <= '1;
            st_q.run    <= 1'b0;
            st_q.rsten  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reload_val = st_q.reload;
    assign run_en     = st_q.run;
    assign rst_en     = st_q.rsten;

    p_locked_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.locked && bus_we && sel_reload) |=> $stable(st_q.reload));

    p_locked_ctrl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.locked && bus_we && sel_ctrl) |=> ($stable(st_q.run) && $stable(st_q.rsten)));

    p_key_unlock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel_key && bus_wdata == DATA_W'(UNLOCK_KEY)) |=> !st_q.locked);
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             load_wr,
    input  logic [CNT_W-1:0] load_data,
    input  logic             ack_wr,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] cnt_val,
    output logic             expire
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t st_d, st_q;
    logic at_zero;

    always_comb begin
        at_zero = (st_q.cnt == '0);
        expire  = run_en && at_zero && !load_wr && !ack_wr;
        st_d    = st_q;
        if (load_wr) begin
            st_d.cnt = load_data;
        end else if (ack_wr) begin
            st_d.cnt = reload_val;
        end else if (run_en) begin
            if (at_zero) begin
                st_d.cnt = reload_val;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_val = st_q.cnt;

    p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !load_wr && !ack_wr && st_q.cnt != '0)
        |=> (st_q.cnt == $past(st_q.cnt) - CNT_W'(1)));

    p_count_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !load_wr && !ack_wr) |=> $stable(st_q.cnt));

    p_load_now_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr |=> (st_q.cnt == $past(load_data)));
endmodule

// File: rtl/kwd_escalate.sv
module kwd_escalate (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic ack_wr,
    input  logic rst_en,
    output logic irq_pend,
    output logic sys_rst
);
    typedef struct packed {
        logic irq;
        logic rst;
    } esc_t;

    esc_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.rst = 1'b0;
        if (ack_wr) begin
            st_d.irq = 1'b0;
        end else if (expire) begin
            if (!st_q.irq) begin
                st_d.irq = 1'b1;
            end else if (rst_en && !st_q.rst) begin
                st_d.rst = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_pend = st_q.irq;
    assign sys_rst  = st_q.rst;

    p_rst_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rst |=> !st_q.rst);

    p_rst_keeps_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rst |-> st_q.irq);

    p_rst_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_en |=> !st_q.rst);

    p_ack_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_wr |=> !st_q.irq);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              sys_rst_o
);
    logic [CNT_W-1:0] cnt_val, reload_val, load_data;
    logic run_en, rst_en, load_wr, ack_wr, expire, irq_pend, irq_vis;

    assign irq_vis = irq_pend && run_en;

    kwd_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .cnt_val    (cnt_val),
        .irq_vis    (irq_vis),
        .bus_rdata  (bus_rdata),
        .reload_val (reload_val),
        .load_data  (load_data),
        .run_en     (run_en),
        .rst_en     (rst_en),
        .load_wr    (load_wr),
        .ack_wr     (ack_wr)
    );

    kwd_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .load_wr    (load_wr),
        .load_data  (load_data),
        .ack_wr     (ack_wr),
        .reload_val (reload_val),
        .cnt_val    (cnt_val),
        .expire     (expire)
    );

    kwd_escalate u_esc (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire   (expire),
        .ack_wr   (ack_wr),
        .rst_en   (rst_en),
        .irq_pend (irq_pend),
        .sys_rst  (sys_rst_o)
    );

    assign irq_o = irq_vis;

    p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |-> !irq_o);

    p_first_expiry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !irq_pend) |=> (irq_pend && cnt_val == $past(reload_val)));
endmodule

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;
    localparam logic [31:0] KEY = 32'h1ACCE551;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, sys_rst_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int rst_seen = 0;

    always #2 clk = ~clk;  // 250 MHz

    keyed_watchdog u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
        .sys_rst_o(sys_rst_o)
    );

    // Behavioural reference model
    bit          m_locked;
    logic [31:0] m_reload, m_cnt;
    bit          m_run, m_rsten, m_irq, m_rst;

    always @(posedge clk) begin
        bit wr_ok, do_load, do_ack, fire;
        if (!rst_n) begin
            m_locked = 1; m_reload = 32'hFFFFFFFF; m_cnt = 32'hFFFFFFFF;
            m_run = 0; m_rsten = 0; m_irq = 0; m_rst = 0;
        end else begin
            wr_ok   = bus_we && !m_locked;
            do_load = wr_ok && bus_addr == 12'h000;
            do_ack  = wr_ok && bus_addr == 12'h00C && bus_wdata[0];
            fire    = m_run && m_cnt == 0 && !do_load && !do_ack;
            // reset request first, from pre-edge state
            m_rst = fire && m_irq && m_rsten && !m_rst;
            if (do_ack) m_irq = 0;
            else if (fire) m_irq = 1;
            if (do_load) m_cnt = bus_wdata;
            else if (do_ack) m_cnt = m_reload;
            else if (m_run) m_cnt = (m_cnt == 0) ? m_reload : m_cnt - 1;
            if (do_load) m_reload = bus_wdata;
            if (wr_ok && bus_addr == 12'h008) begin
                m_run = bus_wdata[1]; m_rsten = bus_wdata[0];
            end
            if (bus_we && bus_addr == 12'hC00) m_locked = (bus_wdata != KEY);
        end
    end

    function automatic logic [31:0] m_read(input logic [11:0] a);
        case (a)
            12'h000: return m_reload;
            12'h004: return m_cnt;
            12'h008: return {30'b0, m_run, m_rsten};
            12'h014: return {31'b0, m_irq && m_run};
            12'hC00: return {31'b0, m_locked};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic report;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Per-cycle comparison of the outputs against the model (R7, R8, R9, R11)
    always @(negedge clk) begin
        if (rst_n) begin
            check("R7/R8/R9/R11 per-cycle irq_o", {31'b0, irq_o}, {31'b0, m_irq && m_run});
            check("R8/R9 per-cycle sys_rst_o", {31'b0, sys_rst_o}, {31'b0, m_rst});
            if (sys_rst_o) rst_seen++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a; bus_we = 1'b0;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v, v2;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);

        // R1 reset state
        rd(12'hC00, v); check("R1 key reads locked", v, 32'h1);
        rd(12'h000, v); check("R1 reload default", v, 32'hFFFFFFFF);
        rd(12'h008, v); check("R1 control zero", v, 32'h0);
        rd(12'h014, v); check("R1 status zero", v, 32'h0);
        check("R1 outputs low", {30'b0, irq_o, sys_rst_o}, 32'h0);

        // R2 locked writes ignored
        wr(12'h000, 32'h5);
        rd(12'h000, v); check("R2 locked reload write ignored", v, 32'hFFFFFFFF);
        rd(12'h004, v); check("R2 locked write leaves count", v, 32'hFFFFFFFF);
        wr(12'h008, 32'h3);
        rd(12'h008, v); check("R2 locked control write ignored", v, 32'h0);

        // R3 unlock and relock
        wr(12'hC00, KEY);
        rd(12'hC00, v); check("R3 key unlocks", v, 32'h0);
        wr(12'hC00, ~KEY);
        rd(12'hC00, v); check("R3 inverse relocks", v, 32'h1);
        wr(12'h000, 32'h7);
        rd(12'h000, v); check("R3 relocked write ignored", v, 32'hFFFFFFFF);
        wr(12'hC00, KEY);
        wr(12'hC00, 32'h1234);
        rd(12'hC00, v); check("R3 arbitrary value relocks", v, 32'h1);
        wr(12'hC00, KEY);

        // R5 control reserved bits
        wr(12'h008, 32'hFFFFFFFD);
        rd(12'h008, v); check("R5 reserved bits read zero", v, 32'h1);
        wr(12'h008, 32'h0);

        // R4 reload write loads counter at once
        wr(12'h000, 32'd20);
        rd(12'h004, v); check("R4 count loaded", v, 32'd20);

        // R6 count, freeze, resume
        wr(12'h008, 32'h2);
        wait_n(3);
        rd(12'h004, v); check("R6 counting down", v, m_read(12'h004));
        check("R6 count below load", {31'b0, v < 32'd20}, 32'h1);
        wr(12'h008, 32'h0);
        rd(12'h004, v);
        wait_n(5);
        rd(12'h004, v2); check("R6 frozen count holds", v2, v);
        wr(12'h008, 32'h2);
        wait_n(2);
        rd(12'h004, v2); check("R6 resume without reload", v2, v - 32'd2);

        // R12 reads while locked
        wr(12'hC00, ~KEY);
        rd(12'h004, v); check("R12 live count while locked", v, m_read(12'h004));
        rd(12'h008, v); check("R12 control readable while locked", v, 32'h2);
        wr(12'hC00, KEY);

        // R7 first expiry
        wr(12'h000, 32'd10);
        bus_addr = 12'h004;
        wait_n(10);
        check("R7 no irq before expiry", {31'b0, irq_o}, 32'h0);
        rd(12'h004, v); check("R7 count at zero", v, 32'h0);
        wait_n(1);
        check("R7 irq after expiry", {31'b0, irq_o}, 32'h1);
        rd(12'h004, v); check("R7 counter reloaded", v, 32'd10);

        // R9 second expiry with escalation disabled
        rst_seen = 0;
        wait_n(14);
        check("R9 no reset when disabled", rst_seen, 0);
        check("R9 irq still pending", {31'b0, irq_o}, 32'h1);

        // R11 masking by control bit 1
        wr(12'h008, 32'h0);
        check("R11 irq masked", {31'b0, irq_o}, 32'h0);
        rd(12'h014, v); check("R11 status masked", v, 32'h0);
        wr(12'h008, 32'h2);
        check("R11 irq visible again", {31'b0, irq_o}, 32'h1);
        rd(12'h014, v); check("R11 status set", v, 32'h1);

        // R2 locked acknowledge ignored
        wr(12'hC00, ~KEY);
        wr(12'h00C, 32'h1);
        check("R2 locked ack ignored", {31'b0, irq_o}, 32'h1);
        wr(12'hC00, KEY);

        // R10 acknowledge
        wr(12'h00C, 32'h2);
        check("R10 ack bit0 clear no effect", {31'b0, irq_o}, 32'h1);
        wr(12'h00C, 32'h1);
        check("R10 ack clears irq", {31'b0, irq_o}, 32'h0);
        rd(12'h004, v); check("R10 ack reloads count", v, 32'd10);

        // R8 escalation to reset
        wr(12'h008, 32'h3);
        wr(12'h000, 32'd4);
        wait_n(4);
        check("R8 no irq yet", {31'b0, irq_o}, 32'h0);
        wait_n(1);
        check("R8 first expiry irq", {31'b0, irq_o}, 32'h1);
        check("R8 no reset on first", {31'b0, sys_rst_o}, 32'h0);
        wait_n(5);
        check("R8 reset on second expiry", {31'b0, sys_rst_o}, 32'h1);
        check("R8 irq kept at reset", {31'b0, irq_o}, 32'h1);
        wait_n(1);
        check("R8 reset is one cycle", {31'b0, sys_rst_o}, 32'h0);
        wr(12'h008, 32'h0);
        wait_n(2);

        report();
    end
endmodule